// File: doc/BRIEF.md
# Uncached Write Combining Buffer

This block collects stores aimed at uncached physical space, recognised by the most significant address bit, and gathers those that fall in the same 32-byte aligned block into one buffer entry. When an entry closes, it joins a small in-order drain queue. It leaves the queue as a block write of two 16-byte beats. Each beat carries a 4-bit mask that marks which of its four 32-bit units hold store data.

An entry closes in three cases: a full or write-only barrier strobe arrives, a store misses the open entry, or all eight units of the block become valid. At most one entry is open at any time, and it is always the newest one. Stores with the uncached bit clear pass through to the caches elsewhere, and this block takes no notice of them. When every entry is occupied and a store needs a fresh entry, the block raises a stall. The producer then holds the store until a slot drains.

Top module: `uc_wcb`

## Requirements
- R1: After reset, `bus_valid` and `st_stall` are low and the buffer is empty.
- R2: A store with address bit 39 clear is ignored. It never stalls, never merges and never produces a bus write.
- R3: Uncached stores to the same 32-byte block are merged into a single block write while that block's entry is open.
- R4: `st_size`=0 writes one 32-bit unit selected by address bits [4:2], taken from `st_data[31:0]`. `st_size`=1 writes the even/odd unit pair selected by bits [4:3], with `st_data[31:0]` in the lower unit and `st_data[63:32]` in the upper unit. Address bits below the store size are ignored.
- R5: A store to a unit that is already valid in the open entry replaces that unit's data, so the newest value is sent.
- R6: A pulse on `mb` or `wmb` closes the open entry. A store accepted in the same cycle is merged first, and the entry then closes with it, so later stores start a new entry.
- R7: An uncached store that misses the open entry closes it and allocates a new entry.
- R8: An entry whose eight units are all valid closes at once, with no barrier needed.
- R9: A block write is two beats. On beat 0 (`bus_beat`=0) the block presents units 0–3 with `bus_mask[i]` marking unit i. On beat 1 it presents units 4–7 the same way. `bus_addr` is the block address with bits [4:0] zero. Units whose mask bit is clear carry zero data. All outputs hold while `bus_ready` is low.
- R10: Block writes leave in the order their entries were allocated.
- R11: With 4 entries occupied, an uncached store that misses the open entry sees `st_stall` high and is not taken. A store that hits the open entry is still accepted.
- R12: The open entry is never sent. It waits until one of the R6–R8 events closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | 40 | Store physical byte address; bit 39 marks uncached |
| st_size | input | 1 | 0: 4-byte store, 1: 8-byte store |
| st_data | input | 64 | Store data, little-endian |
| st_stall | output | 1 | Store cannot be taken this cycle; hold it |
| mb | input | 1 | Full memory barrier strobe |
| wmb | input | 1 | Write barrier strobe |
| bus_valid | output | 1 | Block write beat present |
| bus_ready | input | 1 | Bus takes the current beat |
| bus_addr | output | 40 | Block-aligned write address |
| bus_beat | output | 1 | Beat index within the block write |
| bus_data | output | 128 | Beat data, units 0–3 or 4–7 |
| bus_mask | output | 4 | Per-unit valid bits for the beat |

## Verification
The hardest state to reach is a full buffer in which the newest entry is still open. In that state a store that misses must stall, while a store that hits the open entry must still merge. The stimulus gets there by holding `bus_ready` low and issuing stores to four distinct blocks. It then offers a fifth block, and after that a store to the fourth block. Random phases throttle `bus_ready` and draw addresses from a handful of blocks, which reaches merges, overwrites, barrier-coincident stores and automatic full-block closes in many interleavings.

// File: rtl/uc_wcb.sv
`timescale 1ns/1ps
module uc_wcb #(
  parameter int ADDR_W  = 40,
  parameter int NUM_ENT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_size,
  input  logic [63:0]       st_data,
  output logic              st_stall,
  input  logic              mb,
  input  logic              wmb,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_beat,
  output logic [127:0]      bus_data,
  output logic [3:0]        bus_mask
);
  localparam int UNIT_W = 32;
  localparam int UNITS  = 8;
  localparam int HALF   = UNITS / 2;
  localparam int OFF_W  = 5;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = UNIT_W * UNITS;
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W  = $clog2(NUM_ENT + 1);

  logic [BLK_W-1:0]  ent_blk  [NUM_ENT];
  logic [LINE_W-1:0] ent_data [NUM_ENT];
  logic [UNITS-1:0]  ent_mask [NUM_ENT];
  logic [IDX_W-1:0]  head_q, tail_q, last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              open_q, beat_q;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  wire              uc      = st_valid && st_addr[ADDR_W-1];
  wire [BLK_W-1:0]  st_blk  = st_addr[ADDR_W-1:OFF_W];
  wire              hit     = open_q && (ent_blk[last_q] == st_blk);
  wire              full    = (cnt_q == CNT_W'(NUM_ENT));
  wire              take    = uc && !st_stall;
  wire              alloc   = take && !hit;
  wire              barrier = mb || wmb;
  wire [2:0]        unit    = st_addr[4:2];
  wire [UNITS-1:0]  umask   = st_size ? (UNITS'(2'b11) << {unit[2:1], 1'b0})
                                      : (UNITS'(1'b1) << unit);
  wire [IDX_W-1:0]  wr_idx  = hit ? last_q : tail_q;
  wire [UNITS-1:0]  new_mask = (alloc ? '0 : ent_mask[wr_idx]) | umask;
  wire              pop     = bus_valid && bus_ready && beat_q;

  assign st_stall  = uc && !hit && full;
  assign bus_valid = (cnt_q != '0) && !(open_q && cnt_q == CNT_W'(1));
  assign bus_addr  = {ent_blk[head_q], {OFF_W{1'b0}}};
  assign bus_beat  = beat_q;
  assign bus_data  = beat_q ? ent_data[head_q][LINE_W-1:LINE_W/2]
                            : ent_data[head_q][LINE_W/2-1:0];
  assign bus_mask  = beat_q ? ent_mask[head_q][UNITS-1:HALF]
                            : ent_mask[head_q][HALF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
      beat_q <= 1'b0;
    end else begin
      if (bus_valid && bus_ready) beat_q <= !beat_q;
      if (pop) head_q <= nxt(head_q);
      if (alloc) begin
        tail_q <= nxt(tail_q);
        last_q <= tail_q;
      end
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
      if (take)         open_q <= !(barrier || new_mask == '1);
      else if (barrier) open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        ent_blk[e]  <= '0;
        ent_data[e] <= '0;
        ent_mask[e] <= '0;
      end
    end else if (take) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        if (wr_idx == IDX_W'(e)) begin
          ent_mask[e] <= new_mask;
          if (alloc) ent_blk[e] <= st_blk;
          for (int k = 0; k < UNITS; k++) begin
            if (umask[k])
              ent_data[e][k*UNIT_W +: UNIT_W] <= (st_size && (k % 2 == 1)) ? st_data[63:32] : st_data[31:0];
            else if (alloc)
              ent_data[e][k*UNIT_W +: UNIT_W] <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uc_wcb_chk.sv
`timescale 1ns/1ps
module uc_wcb_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic [ADDR_W-1:0] st_addr,
  input logic              st_size,
  input logic [63:0]       st_data,
  input logic              st_stall,
  input logic              mb,
  input logic              wmb,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_beat,
  input logic [127:0]      bus_data,
  input logic [3:0]        bus_mask
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !bus_valid && !st_stall);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
                                && $stable(bus_mask) && $stable(bus_beat));

  // R9
  beat_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_beat |=> bus_valid && bus_beat && $stable(bus_addr));

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr[4:0] == 5'd0 && bus_addr[ADDR_W-1]);

  // R2
  cached_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_addr[ADDR_W-1] |-> !st_stall);

  // R11
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> st_valid && st_addr[ADDR_W-1]);

  for (genvar i = 0; i < 4; i++) begin : g_zero
    // R9
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_mask[i] |-> bus_data[i*32 +: 32] == 32'd0);
  end
endmodule

bind uc_wcb uc_wcb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/uc_wcb_tb.sv
`timescale 1ns/1ps
module uc_wcb_tb;
  logic         clk = 0, rst_n = 0;
  logic         st_valid = 0, st_size = 0, mb = 0, wmb = 0, bus_ready = 0;
  logic [39:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic         st_stall, bus_valid, bus_beat;
  logic [39:0]  bus_addr;
  logic [127:0] bus_data;
  logic [3:0]   bus_mask;

  uc_wcb u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, n_writes = 0, rdy_pct = 100;
  bit hold_low = 0, done = 0;

  logic [34:0]  q_blk  [$];
  logic [7:0]   q_mask [$];
  logic [255:0] q_data [$];
  bit           m_open = 0, m_beat = 0;
  logic [34:0]  m_blk;
  logic [7:0]   m_mask;
  logic [255:0] m_data;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] unit_mask(input logic [39:0] a, input bit sz);
    return sz ? (8'b11 << {a[4:3], 1'b0}) : (8'b1 << a[4:2]);
  endfunction

  task automatic close_open();
    q_blk.push_back(m_blk); q_mask.push_back(m_mask); q_data.push_back(m_data);
    m_open = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit uc, hit, e_stall, e_valid;
      logic [7:0] um;
      uc = st_valid && st_addr[39];
      hit = m_open && (m_blk == st_addr[39:5]);
      e_stall = uc && !hit && (q_blk.size() + int'(m_open) == 4);
      chk(st_stall === e_stall, "R11 stall", 256'(st_stall), 256'(e_stall));
      e_valid = q_blk.size() != 0;
      chk(bus_valid === e_valid, "R12 bus_valid", 256'(bus_valid), 256'(e_valid));
      if (bus_valid && e_valid) begin
        chk(bus_beat === m_beat, "R9 beat", 256'(bus_beat), 256'(m_beat));
        chk(bus_addr === {q_blk[0], 5'd0}, "R10 order addr", 256'(bus_addr), 256'({q_blk[0], 5'd0}));
        chk(bus_mask === (m_beat ? q_mask[0][7:4] : q_mask[0][3:0]), "R4 mask",
            256'(bus_mask), 256'(m_beat ? q_mask[0][7:4] : q_mask[0][3:0]));
        chk(bus_data === (m_beat ? q_data[0][255:128] : q_data[0][127:0]), "R5 R9 data",
            256'(bus_data), 256'(m_beat ? q_data[0][255:128] : q_data[0][127:0]));
      end
      if (bus_valid && bus_ready && e_valid) begin
        if (m_beat) begin
          void'(q_blk.pop_front()); void'(q_mask.pop_front()); void'(q_data.pop_front());
          n_writes++;
        end
        m_beat = !m_beat;
      end
      if (uc && !e_stall) begin
        if (!hit) begin
          if (m_open) close_open();
          m_open = 1; m_blk = st_addr[39:5]; m_mask = '0; m_data = '0;
        end
        um = unit_mask(st_addr, st_size);
        m_mask |= um;
        for (int k = 0; k < 8; k++)
          if (um[k]) m_data[k*32 +: 32] = (st_size && k % 2 == 1) ? st_data[63:32] : st_data[31:0];
      end
      if (m_open && (mb || wmb || m_mask == 8'hFF)) close_open();
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      bus_ready = hold_low ? 1'b0 : (($urandom % 100) < rdy_pct);
    end
  end

  task automatic store(input logic [39:0] a, input bit sz, input logic [63:0] d,
                       input bit m = 0, input bit w = 0);
    @(posedge clk); #1;
    st_valid = 1; st_addr = a; st_size = sz; st_data = d; mb = m; wmb = w;
    @(negedge clk);
    while (st_stall) @(negedge clk);
  endtask

  task automatic barrier(input bit m, input bit w);
    @(posedge clk); #1;
    st_valid = 0; mb = m; wmb = w;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    st_valid = 0; mb = 0; wmb = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    for (int i = 0; i < 400 && q_blk.size() != 0; i++) @(negedge clk);
  endtask

  localparam logic [39:0] UC = 40'h80_0000_0000;

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!bus_valid && !st_stall, "R1 reset", 256'({bus_valid, st_stall}), 256'(0));

    // R2: cached stores ignored
    base = n_writes;
    store(40'h00_0000_1000, 0, 64'h11);
    store(40'h00_0000_1008, 1, 64'h22, 1, 0);
    drain();
    chk(n_writes == base, "R2 cached ignored", 256'(n_writes - base), 256'(0));

    // R3 R4: merge of mixed sizes
    base = n_writes;
    store(UC | 40'h100 | 40'h4, 0, 64'hAAAA_1111);
    store(UC | 40'h100 | 40'h10, 1, 64'h2222_3333_4444_5555);
    store(UC | 40'h100 | 40'h1F, 0, 64'h7777);
    barrier(0, 1);
    drain();
    chk(n_writes == base + 1, "R3 merge", 256'(n_writes - base), 256'(1));

    // R5: overwrite
    base = n_writes;
    store(UC | 40'h200 | 40'h8, 0, 64'hDEAD);
    store(UC | 40'h200 | 40'h8, 0, 64'hBEEF);
    barrier(1, 0);
    drain();
    chk(n_writes == base + 1, "R5 overwrite", 256'(n_writes - base), 256'(1));

    // R6: store with barrier closes after merge
    base = n_writes;
    store(UC | 40'h300, 0, 64'h1, 1, 0);
    store(UC | 40'h304, 0, 64'h2);
    barrier(0, 1);
    drain();
    chk(n_writes == base + 2, "R6 barrier", 256'(n_writes - base), 256'(2));

    // R7: miss allocates
    base = n_writes;
    store(UC | 40'h400, 0, 64'h3);
    store(UC | 40'h420, 0, 64'h4);
    barrier(1, 0);
    drain();
    chk(n_writes == base + 2, "R7 miss", 256'(n_writes - base), 256'(2));

    // R8: full block closes by itself
    base = n_writes;
    for (int i = 0; i < 4; i++) store(UC | 40'h500 | 40'(i * 8), 1, {32'(i * 2 + 1), 32'(i * 2)});
    drain();
    chk(n_writes == base + 1, "R8 full close", 256'(n_writes - base), 256'(1));

    // R12: open entry not sent
    base = n_writes;
    store(UC | 40'h600, 0, 64'h9);
    idle(20);
    chk(n_writes == base && !bus_valid, "R12 open held", 256'(n_writes - base), 256'(0));
    barrier(1, 0);
    drain();
    chk(n_writes == base + 1, "R12 after close", 256'(n_writes - base), 256'(1));

    // R11: full buffer with open newest
    base = n_writes;
    hold_low = 1;
    for (int i = 0; i < 4; i++) store(UC | 40'(32'h1000 + i * 32), 0, 64'(i));
    @(posedge clk); #1;
    st_valid = 1; st_addr = UC | 40'h2000; st_size = 0; st_data = 64'h55; mb = 0; wmb = 0;
    @(negedge clk);
    chk(st_stall === 1'b1, "R11 stall on miss", 256'(st_stall), 256'(1));
    @(posedge clk); #1;
    st_addr = UC | 40'h1064; st_data = 64'h66;
    @(negedge clk);
    chk(st_stall === 1'b0, "R11 hit accepted", 256'(st_stall), 256'(0));
    idle(1);
    hold_low = 0;
    store(UC | 40'h2000, 0, 64'h55);
    barrier(1, 0);
    drain();
    chk(n_writes == base + 5, "R11 all drained", 256'(n_writes - base), 256'(5));

    // random phase
    rdy_pct = 60;
    for (int i = 0; i < 3000; i++) begin
      logic [39:0] a;
      a = {($urandom % 8) != 0, 30'd0, 4'($urandom % 3), 5'($urandom)};
      store(a, $urandom % 2, {$urandom, $urandom}, ($urandom % 16) == 0, ($urandom % 16) == 1);
      if ((i % 200) == 100) begin hold_low = 1; idle(12); hold_low = 0; end
    end
    barrier(1, 0);
    rdy_pct = 100;
    drain();
    chk(q_blk.size() == 0 && !m_open, "R10 random drained", 256'(q_blk.size()), 256'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule